// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Register Bank

This block holds the digital codes of a sixteen-channel, eight-bit multiple-output DAC that a host addresses like memory. Each channel owns two registers: a staging register that the host writes over an address/data bus, and an output register whose value drives the converter. Writes land in the staging rank only, so a host can prepare new codes for every channel without disturbing the analog outputs.

A global active-low transfer strobe copies every staging register into its output register on the same clock edge, so all outputs move together. While the strobe is held low the bank is transparent: a write reaches the addressed output register on the edge that captures it, and a write coinciding with a transfer delivers the freshly written value. As soon as the strobe returns high the host may begin staging the next set of codes while the converters settle. A reset drives both ranks to a build-time code, either zero-scale or mid-scale (the latter gives 0 V in a bipolar setup). The host can read back either rank through a registered read port.

Top module: `dacbank_top`

## Requirements
- R1: The bank has NCH=16 channels of DW=8 bits; channel i's output code appears on `dac_codes[8*i+7:8*i]`, and `addr` selects channel number `addr`.
- R2: A write (`wr_en`=1) on an edge where `load_n`=1 updates only the addressed staging register; `dac_codes` does not change on that edge.
- R3: On every edge where `load_n`=0, all output registers take the staging values, so all channels change on the same edge.
- R4: While `load_n`=0, a write places `wdata` into the addressed output register on the same edge that captures the write.
- R5: When a write and `load_n`=0 share an edge, the addressed output register receives the new `wdata`, not the old staging value; other channels receive their staging values.
- R6: Writes on edges after `load_n` has returned high change only staging registers; the outputs keep the values of the last transfer.
- R7: With `rst`=1 at an edge, every staging and output register becomes the reset code (8'h00 when MID_SCALE=0, 8'h80 when MID_SCALE=1) and `rdata` becomes 8'h00.
- R8: With `rd_en`=1 and `rb_sel`=0 at an edge, `rdata` after that edge equals the staging register of `addr` as it was before the edge.
- R9: With `rd_en`=1 and `rb_sel`=1 at an edge, `rdata` after that edge equals the output register of `addr` as it was before the edge.
- R10: `rdata` keeps its value on edges where `rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 4 | Channel address for write and read |
| wr_en | input | 1 | Write strobe for the staging register at `addr` |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, loads `rdata` |
| rb_sel | input | 1 | Readback source: 0 staging rank, 1 output rank |
| load_n | input | 1 | Transfer strobe, active low; held low gives transparent writes |
| rdata | output | 8 | Registered readback data |
| dac_codes | output | 128 | All output register codes, channel 0 in the low byte |

## Verification
The assertions take for granted that `addr`, `wdata`, `wr_en`, `rd_en`, `rb_sel` and `load_n` are clean, known values at every sampling edge after reset, and that reset is high on the first edge so the captured copies in the checker start from a defined state. The stimulus drives every input only on the falling clock edge, holds reset for the opening cycles and again once mid-run, and keeps `addr` inside the sixteen channels, so every assertion antecedent sees settled values.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    localparam int CH_COUNT = 16;
    localparam int CODE_W   = 8;

    // Source of the readback path
    typedef enum logic {
        RB_STAGE  = 1'b0,
        RB_OUTPUT = 1'b1
    } rb_src_e;

    // Reset code: zero-scale or mid-scale
    function automatic logic [CODE_W-1:0] reset_code(input bit mid);
        logic [CODE_W-1:0] c;
        c = '0;
        if (mid) c[CODE_W-1] = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/dacbank_wdec.sv
module dacbank_wdec #(
    parameter int NCH = 16,
    localparam int AW = $clog2(NCH)
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    output logic [NCH-1:0] lane_we
);
    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign lane_we[i] = wr_en && (addr == AW'(i));
    end
endmodule

// File: rtl/dacbank_stage.sv
module dacbank_stage #(
    parameter int NCH = 16,
    parameter int DW  = 8,
    parameter logic [DW-1:0] RST_CODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    lane_we,
    input  logic [DW-1:0]     wdata,
    output logic [NCH*DW-1:0] stage_next,
    output logic [NCH*DW-1:0] stage_q
);
    for (genvar i = 0; i < NCH; i++) begin : g_lane
        assign stage_next[i*DW +: DW] = lane_we[i] ? wdata : stage_q[i*DW +: DW];

        always_ff @(posedge clk) begin
            if (rst) stage_q[i*DW +: DW] <= RST_CODE;
            else     stage_q[i*DW +: DW] <= stage_next[i*DW +: DW];
        end
    end
endmodule

// File: rtl/dacbank_out.sv
module dacbank_out #(
    parameter int NCH = 16,
    parameter int DW  = 8,
    parameter logic [DW-1:0] RST_CODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic [NCH*DW-1:0] stage_next,
    output logic [NCH*DW-1:0] out_q
);
    for (genvar i = 0; i < NCH; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)         out_q[i*DW +: DW] <= RST_CODE;
            else if (!load_n) out_q[i*DW +: DW] <= stage_next[i*DW +: DW];
        end
    end
endmodule

// File: rtl/dacbank_rdport.sv
module dacbank_rdport
    import dacbank_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 8,
    localparam int AW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  rb_src_e           src,
    input  logic [AW-1:0]     addr,
    input  logic [NCH*DW-1:0] stage_q,
    input  logic [NCH*DW-1:0] out_q,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] sel_stage;
    logic [DW-1:0] sel_out;

    always_comb begin
        sel_stage = stage_q[addr*DW +: DW];
        sel_out   = out_q[addr*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (src)
                RB_STAGE:  rdata <= sel_stage;
                RB_OUTPUT: rdata <= sel_out;
                default:   rdata <= sel_stage;
            endcase
        end
    end
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
    import dacbank_pkg::*;
#(
    parameter int NCH       = CH_COUNT,
    parameter int DW        = CODE_W,
    parameter bit MID_SCALE = 1'b0,
    localparam int AW       = $clog2(NCH),
    localparam logic [DW-1:0] RST_CODE = MID_SCALE ? DW'(1) << (DW-1) : '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    input  logic              rd_en,
    input  logic              rb_sel,
    input  logic              load_n,
    output logic [DW-1:0]     rdata,
    output logic [NCH*DW-1:0] dac_codes
);
    logic [NCH-1:0]    lane_we;
    logic [NCH*DW-1:0] stage_next;
    logic [NCH*DW-1:0] stage_q;
    logic [NCH*DW-1:0] out_q;
    rb_src_e           src;

    assign src = rb_sel ? RB_OUTPUT : RB_STAGE;

    dacbank_wdec #(.NCH(NCH)) u_wdec (
        .wr_en  (wr_en),
        .addr   (addr),
        .lane_we(lane_we)
    );

    dacbank_stage #(.NCH(NCH), .DW(DW), .RST_CODE(RST_CODE)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .lane_we   (lane_we),
        .wdata     (wdata),
        .stage_next(stage_next),
        .stage_q   (stage_q)
    );

    dacbank_out #(.NCH(NCH), .DW(DW), .RST_CODE(RST_CODE)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load_n    (load_n),
        .stage_next(stage_next),
        .out_q     (out_q)
    );

    dacbank_rdport #(.NCH(NCH), .DW(DW)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .src    (src),
        .addr   (addr),
        .stage_q(stage_q),
        .out_q  (out_q),
        .rdata  (rdata)
    );

    assign dac_codes = out_q;
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
    parameter int NCH       = 16,
    parameter int DW        = 8,
    parameter bit MID_SCALE = 1'b0,
    localparam int AW       = $clog2(NCH),
    localparam logic [DW-1:0] RST_CODE = MID_SCALE ? DW'(1) << (DW-1) : '0
) (
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     addr,
    input logic              wr_en,
    input logic [DW-1:0]     wdata,
    input logic              rd_en,
    input logic              rb_sel,
    input logic              load_n,
    input logic [DW-1:0]     rdata,
    input logic [NCH*DW-1:0] dac_codes
);
    logic [NCH*DW-1:0] dac_prev;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;

    always_ff @(posedge clk) begin
        dac_prev <= dac_codes;
        addr_q   <= addr;
        wdata_q  <= wdata;
    end

    // R7
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (dac_codes == {NCH{RST_CODE}}) && (rdata == '0));

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        load_n |=> $stable(dac_codes));

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_n && wr_en) |=> dac_codes[addr_q*DW +: DW] == wdata_q);

    // R9
    readback_out_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rb_sel) |=> rdata == dac_prev[addr_q*DW +: DW]);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

bind dacbank_top dacbank_chk #(.NCH(NCH), .DW(DW), .MID_SCALE(MID_SCALE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rd_en    (rd_en),
    .rb_sel   (rb_sel),
    .load_n   (load_n),
    .rdata    (rdata),
    .dac_codes(dac_codes)
);

// File: tb/sim_dacbank_top.sv
module sim_dacbank_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int DW  = 8;
    localparam bit MID = 1'b1;
    localparam int RSTV = 128;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] addr = '0;
    logic wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic rd_en = 1'b0;
    logic rb_sel = 1'b0;
    logic load_n = 1'b1;
    logic [7:0] rdata;
    logic [NCH*DW-1:0] dac_codes;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R7";

    int st_m [NCH];
    int out_m [NCH];
    int rd_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacbank_top #(.NCH(NCH), .DW(DW), .MID_SCALE(MID)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rb_sel(rb_sel), .load_n(load_n),
        .rdata(rdata), .dac_codes(dac_codes)
    );

    // Behavioural reference model, updated on each rising edge
    always @(posedge clk) begin
        int nxt [NCH];
        if (rst) begin
            foreach (st_m[i]) begin st_m[i] = RSTV; out_m[i] = RSTV; end
            rd_m = 0;
        end else begin
            foreach (st_m[i]) nxt[i] = st_m[i];
            if (wr_en) nxt[addr] = wdata;
            if (rd_en) rd_m = rb_sel ? out_m[addr] : st_m[addr];
            if (!load_n) foreach (out_m[i]) out_m[i] = nxt[i];
            foreach (st_m[i]) st_m[i] = nxt[i];
        end
    end

    task automatic compare();
        for (int i = 0; i < NCH; i++) begin
            checks++;
            if (int'(dac_codes[i*DW +: DW]) != out_m[i]) begin
                fails++;
                $display("FAIL %s: channel %0d code actual %0h expected %0h",
                         cur_req, i, dac_codes[i*DW +: DW], out_m[i]);
            end
        end
        checks++;
        if (int'(rdata) != rd_m) begin
            fails++;
            $display("FAIL %s: rdata actual %0h expected %0h", cur_req, rdata, rd_m);
        end
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs
    task automatic step(input logic w, input int a, input int d,
                        input logic r, input logic s, input logic ld);
        @(negedge clk);
        compare();
        wr_en = w; addr = 4'(a); wdata = 8'(d);
        rd_en = r; rb_sel = s; load_n = ld;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: cycles actual %0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        // R7: reset to mid-scale
        cur_req = "R7";
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 1);
        // R1, R2: stage distinct codes in every channel, outputs unchanged
        cur_req = "R2";
        for (int i = 0; i < NCH; i++) step(1, i, i * 17 + 3, 0, 0, 1);
        // R8: read staging rank back
        cur_req = "R8";
        for (int i = 0; i < NCH; i++) step(0, i, 0, 1, 0, 1);
        // R10: idle with rd_en low, rdata holds
        cur_req = "R10";
        step(0, 3, 0, 0, 1, 1);
        step(0, 9, 0, 0, 0, 1);
        // R9: output rank still at reset code
        cur_req = "R9";
        step(0, 5, 0, 1, 1, 1);
        // R3: single-cycle transfer of all channels
        cur_req = "R3";
        step(0, 0, 0, 0, 0, 0);
        // R6: immediate staging after strobe rises
        cur_req = "R6";
        step(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < NCH; i += 3) step(1, i, 8'hF0 ^ i, 0, 0, 1);
        // R1, R9: readback of output rank for all channels
        cur_req = "R1";
        for (int i = 0; i < NCH; i++) step(0, i, 0, 1, 1, 1);
        // R5: write coinciding with a transfer
        cur_req = "R5";
        step(1, 7, 8'h5A, 0, 0, 0);
        step(0, 7, 0, 1, 1, 1);
        step(0, 7, 0, 1, 0, 1);
        // R4: transparent writes while strobe held low
        cur_req = "R4";
        step(1, 2, 8'hFF, 0, 0, 0);
        step(1, 14, 8'h00, 0, 0, 0);
        step(1, 2, 8'h81, 1, 1, 0);
        step(1, 15, 8'hC3, 1, 0, 0);
        step(0, 15, 0, 1, 1, 1);
        // R2: writes with strobe high again do not reach outputs
        cur_req = "R2";
        step(1, 15, 8'h11, 0, 0, 1);
        step(1, 0, 8'h22, 1, 1, 1);
        step(0, 0, 0, 1, 0, 1);
        // R7: reset mid-run
        cur_req = "R7";
        rst = 1'b1;
        step(0, 0, 0, 0, 0, 1);
        rst = 1'b0;
        step(0, 0, 0, 1, 0, 1);
        step(0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 1);
        finish_run();
    end
endmodule